// File: doc/BRIEF.md
# Dual-Port Control Register Bank

This block holds a small set of 64-bit control and status registers that two masters can reach. A sideband configuration master addresses the registers by a direct word index. A memory-mapped master supplies a byte address, which the block turns into a word index by dropping the three low bits and adding a fixed offset, so the memory-mapped window starts at the base-address register. Only whole 8-byte, aligned words can be accessed. Data words are big-endian, with bit 63 the most significant bit.

Some indices are write aliases rather than storage. The fault register can be replaced, ANDed into or ORed into. The control register can be replaced, have bits set, or have bits cleared. The base-address register is masked on write and only the sideband master may change it. From it the block drives a decoded window base and a window enable. A toggle of the remap-enable control bit raises a one-cycle strobe so that logic outside the block can rebuild its address decode. Writes that are not allowed raise a one-cycle reject flag.

Top module: `dual_port_ctl_regs`

## Requirements
- R1: The sideband index is used as given. The memory-mapped index is (byte address >> 3) + 0x0A. A memory-mapped access whose address has any of bits [2:0] set is misaligned: it writes nothing, raises the reject flag, and a read returns all ones.
- R2: Both ports use a request/ready handshake and each transfer takes one cycle. The sideband port is always ready. When both ports request in the same cycle the sideband port is served and mm_ready is low, so the memory-mapped request has to be held.
- R3: A read accepted at a clock edge presents its data with rvalid high in the following cycle, on the port that issued it. The readable indices are 0x00, 0x06, 0x07, 0x0A, 0x0B, 0x0E, 0x0F, 0x14 and 0x15. A read of any other index, including the alias indices, returns 0xFFFFFFFFFFFFFFFF.
- R4: A write to index 0x00 replaces the fault register. A write to 0x01 ANDs the data into it. A write to 0x02 ORs the data into it.
- R5: A write to index 0x0E replaces the control register. A write to 0x12 sets in it the bits that are 1 in the data. A write to 0x13 clears in it the bits that are 1 in the data.
- R6: A sideband write to index 0x0A stores data & 0x0003FFFFFFF00000, plus bit 0 of the data. win_base equals the stored value & 0x0003FFFFFFF00000, and win_en equals its bit 0. A memory-mapped write to that index (byte address 0x00) is rejected and changes nothing.
- R7: A write to index 0x0B stores data & 0x0003FFFF00000000.
- R8: Index 0x15 (interrupt status) is read-only and reads zero. A write to it, or to any index that is neither storage nor an alias, is rejected. wr_reject is high in the cycle after a rejected write and low otherwise.
- R9: A synchronous reset clears every register to zero. The base register then loads (DEF_BASE & 0x0003FFFFFFF00000) | 1, so the window is enabled after reset.
- R10: ctl_remap_strobe is high for exactly the cycle after a write in which bit 62 of the control register changes value. Any write path to the control register counts.
- R11: Indices 0x06, 0x07, 0x0F and 0x14 are plain registers that store all 64 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sb_req | input | 1 | Sideband request |
| sb_we | input | 1 | Sideband write (1) or read (0) |
| sb_idx | input | IDX_W | Sideband word index |
| sb_wdata | input | 64 | Sideband write data |
| sb_ready | output | 1 | Sideband ready (always 1) |
| sb_rvalid | output | 1 | Sideband read data valid |
| sb_rdata | output | 64 | Sideband read data |
| mm_req | input | 1 | Memory-mapped request |
| mm_we | input | 1 | Memory-mapped write (1) or read (0) |
| mm_addr | input | ADDR_W | Memory-mapped byte address |
| mm_wdata | input | 64 | Memory-mapped write data |
| mm_ready | output | 1 | Memory-mapped request accepted this cycle |
| mm_rvalid | output | 1 | Memory-mapped read data valid |
| mm_rdata | output | 64 | Memory-mapped read data |
| wr_reject | output | 1 | A write was refused in the previous cycle |
| win_base | output | 64 | Decoded window base address |
| win_en | output | 1 | Window enable |
| ctl_remap_strobe | output | 1 | One-cycle pulse on a remap-bit change |

## Verification
On every cycle the assertions check the following: sideband precedence, one-cycle read latency on the correct port, the lock that keeps the memory-mapped port from writing the base register, rejection of status and misaligned writes, a cause for every strobe and every window change, and the post-reset window. The AND, OR, set and clear arithmetic, the masking of both base registers, the value returned by each readable index and the all-ones default can be shown only by the bench's scenarios. There, a scoreboard compares each returned read word against values worked out from the requirements.

// File: rtl/crb_pkg.sv
package crb_pkg;
  localparam int DATA_W = 64;

  // word indices whose positions matter to the two address maps
  localparam logic [5:0] IX_FAULT     = 6'h00;
  localparam logic [5:0] IX_FAULT_AND = 6'h01;
  localparam logic [5:0] IX_FAULT_OR  = 6'h02;
  localparam logic [5:0] IX_ACT0      = 6'h06;
  localparam logic [5:0] IX_ACT1      = 6'h07;
  localparam logic [5:0] IX_BASE      = 6'h0A;
  localparam logic [5:0] IX_SBASE     = 6'h0B;
  localparam logic [5:0] IX_CTL       = 6'h0E;
  localparam logic [5:0] IX_EMASK     = 6'h0F;
  localparam logic [5:0] IX_CTL_SET   = 6'h12;
  localparam logic [5:0] IX_CTL_CLR   = 6'h13;
  localparam logic [5:0] IX_DMAUP     = 6'h14;
  localparam logic [5:0] IX_ISTAT     = 6'h15;

  localparam logic [DATA_W-1:0] BASE_KEEP  = 64'h0003_FFFF_FFF0_0000;
  localparam logic [DATA_W-1:0] SBASE_KEEP = 64'h0003_FFFF_0000_0000;
  localparam logic [DATA_W-1:0] ALL_ONES   = {DATA_W{1'b1}};

  typedef enum logic [1:0] {SRC_NONE, SRC_SB, SRC_MM} src_e;

  typedef struct packed {
    logic              vld;
    logic              we;
    logic              ok;
    src_e              src;
    logic [5:0]        idx;
    logic [DATA_W-1:0] wdata;
  } req_t;
endpackage

// File: rtl/crb_index_xlate.sv
module crb_index_xlate #(
  parameter int ADDR_W     = 8,
  parameter int IDX_W      = 6,
  parameter int OFS        = 10,
  parameter int ALIGN_BITS = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic              aligned
);
  localparam int WORD_W = ADDR_W - ALIGN_BITS;

  logic [WORD_W-1:0] word;

  assign word    = addr[ADDR_W-1:ALIGN_BITS];
  assign idx     = IDX_W'(word) + IDX_W'(OFS);
  assign aligned = (addr[ALIGN_BITS-1:0] == '0);
endmodule

// File: rtl/crb_arbiter.sv
module crb_arbiter
  import crb_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic              sb_req,
  input  logic              sb_we,
  input  logic [IDX_W-1:0]  sb_idx,
  input  logic [DATA_W-1:0] sb_wdata,
  input  logic              mm_req,
  input  logic              mm_we,
  input  logic [IDX_W-1:0]  mm_idx,
  input  logic              mm_aligned,
  input  logic [DATA_W-1:0] mm_wdata,
  output logic              mm_ready,
  output req_t              grant
);
  always_comb begin
    mm_ready    = ~sb_req;
    grant       = '0;
    grant.src   = SRC_NONE;
    if (sb_req) begin
      grant.vld   = 1'b1;
      grant.we    = sb_we;
      grant.ok    = 1'b1;
      grant.src   = SRC_SB;
      grant.idx   = 6'(sb_idx);
      grant.wdata = sb_wdata;
    end else if (mm_req) begin
      grant.vld   = 1'b1;
      grant.we    = mm_we;
      grant.ok    = mm_aligned;
      grant.src   = SRC_MM;
      grant.idx   = 6'(mm_idx);
      grant.wdata = mm_wdata;
    end
  end
endmodule

// File: rtl/crb_regfile.sv
module crb_regfile
  import crb_pkg::*;
#(
  parameter logic [DATA_W-1:0] DEF_BASE  = 64'h0000_1234_5678_9ABC,
  parameter int                REMAP_BIT = 62
) (
  input  logic              clk,
  input  logic              rst,
  input  req_t              grant,
  output logic              sb_rvalid,
  output logic [DATA_W-1:0] sb_rdata,
  output logic              mm_rvalid,
  output logic [DATA_W-1:0] mm_rdata,
  output logic              wr_reject,
  output logic [DATA_W-1:0] win_base,
  output logic              win_en,
  output logic              remap_strobe
);
  localparam int NPLAIN = 4;
  localparam logic [NPLAIN*6-1:0] PLAIN_IX = {IX_DMAUP, IX_EMASK, IX_ACT1, IX_ACT0};
  localparam logic [DATA_W-1:0] BASE_RST = (DEF_BASE & BASE_KEEP) | 64'd1;

  logic [DATA_W-1:0] fault_q, fault_n;
  logic [DATA_W-1:0] ctl_q, ctl_n;
  logic [DATA_W-1:0] base_q, base_n;
  logic [DATA_W-1:0] sbase_q, sbase_n;
  logic [DATA_W-1:0] plain_q [NPLAIN];
  logic [NPLAIN-1:0] plain_hit;
  logic [DATA_W-1:0] rd;
  logic              rej_n;
  logic              wr_go;

  assign wr_go = grant.vld & grant.we & grant.ok;

  always_comb begin
    fault_n = fault_q;
    ctl_n   = ctl_q;
    base_n  = base_q;
    sbase_n = sbase_q;
    rej_n   = 1'b0;
    rd      = ALL_ONES;
    for (int i = 0; i < NPLAIN; i++) begin
      plain_hit[i] = (grant.idx == PLAIN_IX[i*6 +: 6]);
    end

    if (grant.ok) begin
      case (grant.idx)
        IX_FAULT: rd = fault_q;
        IX_BASE:  rd = base_q;
        IX_SBASE: rd = sbase_q;
        IX_CTL:   rd = ctl_q;
        IX_ISTAT: rd = '0;
        default: begin
          for (int i = 0; i < NPLAIN; i++) begin
            if (plain_hit[i]) rd = plain_q[i];
          end
        end
      endcase
    end

    if (grant.vld && grant.we) begin
      if (!grant.ok) begin
        rej_n = 1'b1;
      end else begin
        case (grant.idx)
          IX_FAULT:     fault_n = grant.wdata;
          IX_FAULT_AND: fault_n = fault_q & grant.wdata;
          IX_FAULT_OR:  fault_n = fault_q | grant.wdata;
          IX_BASE: begin
            if (grant.src == SRC_MM) rej_n = 1'b1;
            else base_n = grant.wdata & (BASE_KEEP | 64'd1);
          end
          IX_SBASE:     sbase_n = grant.wdata & SBASE_KEEP;
          IX_CTL:       ctl_n = grant.wdata;
          IX_CTL_SET:   ctl_n = ctl_q | grant.wdata;
          IX_CTL_CLR:   ctl_n = ctl_q & ~grant.wdata;
          IX_ISTAT:     rej_n = 1'b1;
          default:      rej_n = ~(|plain_hit);
        endcase
      end
    end
  end

  for (genvar g = 0; g < NPLAIN; g++) begin : g_plain
    always_ff @(posedge clk) begin
      if (rst) plain_q[g] <= '0;
      else if (wr_go && plain_hit[g]) plain_q[g] <= grant.wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_q      <= '0;
      ctl_q        <= '0;
      base_q       <= BASE_RST;
      sbase_q      <= '0;
      wr_reject    <= 1'b0;
      remap_strobe <= 1'b0;
      sb_rvalid    <= 1'b0;
      mm_rvalid    <= 1'b0;
      sb_rdata     <= '0;
      mm_rdata     <= '0;
    end else begin
      fault_q      <= fault_n;
      ctl_q        <= ctl_n;
      base_q       <= base_n;
      sbase_q      <= sbase_n;
      wr_reject    <= rej_n;
      remap_strobe <= ctl_n[REMAP_BIT] ^ ctl_q[REMAP_BIT];
      sb_rvalid    <= grant.vld & ~grant.we & (grant.src == SRC_SB);
      mm_rvalid    <= grant.vld & ~grant.we & (grant.src == SRC_MM);
      if (grant.vld && !grant.we && grant.src == SRC_SB) sb_rdata <= rd;
      if (grant.vld && !grant.we && grant.src == SRC_MM) mm_rdata <= rd;
    end
  end

  assign win_base = base_q & BASE_KEEP;
  assign win_en   = base_q[0];
endmodule

// File: rtl/dual_port_ctl_regs.sv
module dual_port_ctl_regs
  import crb_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter int                IDX_W      = 6,
  parameter int                MM_IDX_OFS = 10,
  parameter logic [63:0]       DEF_BASE   = 64'h0000_1234_5678_9ABC,
  parameter int                REMAP_BIT  = 62
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sb_req,
  input  logic              sb_we,
  input  logic [IDX_W-1:0]  sb_idx,
  input  logic [63:0]       sb_wdata,
  output logic              sb_ready,
  output logic              sb_rvalid,
  output logic [63:0]       sb_rdata,
  input  logic              mm_req,
  input  logic              mm_we,
  input  logic [ADDR_W-1:0] mm_addr,
  input  logic [63:0]       mm_wdata,
  output logic              mm_ready,
  output logic              mm_rvalid,
  output logic [63:0]       mm_rdata,
  output logic              wr_reject,
  output logic [63:0]       win_base,
  output logic              win_en,
  output logic              ctl_remap_strobe
);
  logic [IDX_W-1:0] mm_idx;
  logic             mm_aligned;
  req_t             grant;

  assign sb_ready = 1'b1;

  crb_index_xlate #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFS(MM_IDX_OFS), .ALIGN_BITS(3)
  ) u_xlate (
    .addr(mm_addr), .idx(mm_idx), .aligned(mm_aligned)
  );

  crb_arbiter #(.IDX_W(IDX_W)) u_arb (
    .sb_req(sb_req), .sb_we(sb_we), .sb_idx(sb_idx), .sb_wdata(sb_wdata),
    .mm_req(mm_req), .mm_we(mm_we), .mm_idx(mm_idx), .mm_aligned(mm_aligned),
    .mm_wdata(mm_wdata), .mm_ready(mm_ready), .grant(grant)
  );

  crb_regfile #(.DEF_BASE(DEF_BASE), .REMAP_BIT(REMAP_BIT)) u_rf (
    .clk(clk), .rst(rst), .grant(grant),
    .sb_rvalid(sb_rvalid), .sb_rdata(sb_rdata),
    .mm_rvalid(mm_rvalid), .mm_rdata(mm_rdata),
    .wr_reject(wr_reject), .win_base(win_base), .win_en(win_en),
    .remap_strobe(ctl_remap_strobe)
  );
endmodule

// File: rtl/crb_checker.sv
module crb_checker #(
  parameter int          ADDR_W   = 8,
  parameter int          IDX_W    = 6,
  parameter logic [63:0] DEF_BASE = 64'h0
) (
  input logic              clk,
  input logic              rst,
  input logic              sb_req,
  input logic              sb_we,
  input logic [IDX_W-1:0]  sb_idx,
  input logic              mm_req,
  input logic              mm_we,
  input logic [ADDR_W-1:0] mm_addr,
  input logic              mm_ready,
  input logic              sb_rvalid,
  input logic              mm_rvalid,
  input logic              wr_reject,
  input logic [63:0]       win_base,
  input logic              win_en,
  input logic              ctl_remap_strobe
);
  localparam logic [63:0] KEEP = 64'h0003_FFFF_FFF0_0000;

  logic any_wr;
  assign any_wr = (sb_req && sb_we) || (mm_req && mm_we && mm_ready);

  assert_sb_first_R2: assert property (@(posedge clk) disable iff (rst)
    sb_req |-> !mm_ready);

  assert_one_rvalid_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sb_rvalid, mm_rvalid}));

  assert_sb_latency_R3: assert property (@(posedge clk) disable iff (rst)
    sb_rvalid |-> $past(sb_req && !sb_we));

  assert_mm_latency_R3: assert property (@(posedge clk) disable iff (rst)
    mm_rvalid |-> $past(mm_req && !mm_we && mm_ready));

  assert_misalign_R1: assert property (@(posedge clk) disable iff (rst)
    (mm_req && mm_we && mm_ready && mm_addr[2:0] != 3'd0) |=> wr_reject);

  assert_mm_base_locked_R6: assert property (@(posedge clk) disable iff (rst)
    (mm_req && mm_we && mm_ready && mm_addr == '0) |=>
      (wr_reject && $stable(win_base) && $stable(win_en)));

  assert_base_cause_R6: assert property (@(posedge clk) disable iff (rst)
    (!$stable(win_en) || !$stable(win_base)) |->
      $past(sb_req && sb_we && sb_idx == IDX_W'(6'h0A)));

  assert_istat_reject_R8: assert property (@(posedge clk) disable iff (rst)
    (sb_req && sb_we && sb_idx == IDX_W'(6'h15)) |=> wr_reject);

  assert_reset_window_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (win_en && win_base == (DEF_BASE & KEEP)));

  assert_strobe_cause_R10: assert property (@(posedge clk) disable iff (rst)
    ctl_remap_strobe |-> $past(any_wr));
endmodule

bind dual_port_ctl_regs crb_checker #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DEF_BASE(DEF_BASE)
) u_chk (
  .clk(clk), .rst(rst), .sb_req(sb_req), .sb_we(sb_we), .sb_idx(sb_idx),
  .mm_req(mm_req), .mm_we(mm_we), .mm_addr(mm_addr), .mm_ready(mm_ready),
  .sb_rvalid(sb_rvalid), .mm_rvalid(mm_rvalid), .wr_reject(wr_reject),
  .win_base(win_base), .win_en(win_en), .ctl_remap_strobe(ctl_remap_strobe)
);

// File: tb/dual_port_ctl_regs_test.sv
module dual_port_ctl_regs_test;
  localparam logic [63:0] DEFB   = 64'h0000_1234_5678_9ABC;
  localparam logic [63:0] DEFB_M = 64'h0000_1234_5670_0000;
  localparam logic [63:0] ONES   = 64'hFFFF_FFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sb_req = 0, sb_we = 0;
  logic [5:0]  sb_idx = '0;
  logic [63:0] sb_wdata = '0;
  logic        mm_req = 0, mm_we = 0;
  logic [7:0]  mm_addr = '0;
  logic [63:0] mm_wdata = '0;
  logic        sb_ready, sb_rvalid, mm_ready, mm_rvalid;
  logic [63:0] sb_rdata, mm_rdata, win_base;
  logic        wr_reject, win_en, ctl_remap_strobe;

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [63:0] sb_exp[$], mm_exp[$];
  string       sb_tag[$], mm_tag[$];

  always #4 clk = ~clk;

  dual_port_ctl_regs #(.DEF_BASE(DEFB)) uut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pop expectations as read data comes back
  always @(negedge clk) begin
    if (sb_rvalid) begin
      if (sb_exp.size() == 0) chk("R3 unexpected sb read", 64'd1, 64'd0);
      else chk(sb_tag.pop_front(), sb_rdata, sb_exp.pop_front());
    end
    if (mm_rvalid) begin
      if (mm_exp.size() == 0) chk("R3 unexpected mm read", 64'd1, 64'd0);
      else chk(mm_tag.pop_front(), mm_rdata, mm_exp.pop_front());
    end
  end

  task automatic sb_acc(input bit we, input logic [5:0] idx, input logic [63:0] d,
                        input logic [63:0] exp, input string tag);
    if (!we) begin sb_exp.push_back(exp); sb_tag.push_back(tag); end
    sb_req = 1; sb_we = we; sb_idx = idx; sb_wdata = d;
    @(posedge clk); #1;
    sb_req = 0; sb_we = 0;
  endtask

  task automatic mm_acc(input bit we, input logic [7:0] a, input logic [63:0] d,
                        input logic [63:0] exp, input string tag);
    if (!we) begin mm_exp.push_back(exp); mm_tag.push_back(tag); end
    mm_req = 1; mm_we = we; mm_addr = a; mm_wdata = d;
    @(posedge clk); #1;
    mm_req = 0; mm_we = 0;
  endtask

  task automatic flags(input string tag, input bit rej, input bit strb);
    @(negedge clk);
    chk({tag, " reject"}, {63'd0, wr_reject}, {63'd0, rej});
    chk({tag, " strobe"}, {63'd0, ctl_remap_strobe}, {63'd0, strb});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    chk("watchdog expired", 64'd1, 64'd0);
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R9 reset state
    chk("R9 win_en after reset", {63'd0, win_en}, 64'd1);
    chk("R9 win_base after reset", win_base, DEFB_M);
    chk("R9 strobe idle", {63'd0, ctl_remap_strobe}, 64'd0);
    chk("R2 sb_ready", {63'd0, sb_ready}, 64'd1);
    sb_acc(0, 6'h0A, 0, DEFB_M | 64'd1, "R9 base read");
    sb_acc(0, 6'h00, 0, 64'd0, "R9 fault cleared");
    mm_acc(0, 8'h20, 0, 64'd0, "R9 ctl cleared");

    // R4 fault aliases
    sb_acc(1, 6'h00, 64'hA5A5_A5A5_A5A5_A5A5, 0, "");
    sb_acc(1, 6'h01, 64'hFF00_FF00_FF00_FF00, 0, "");
    sb_acc(0, 6'h00, 0, 64'hA500_A500_A500_A500, "R4 fault AND");
    sb_acc(1, 6'h02, 64'h0000_0000_0000_00FF, 0, "");
    sb_acc(0, 6'h00, 0, 64'hA500_A500_A500_A5FF, "R4 fault OR");

    // R5 / R10 control aliases and remap strobe
    sb_acc(1, 6'h0E, 64'h3, 0, "");
    flags("R10 no toggle on replace", 0, 0);
    sb_acc(1, 6'h12, 64'h4000_0000_0000_0000, 0, "");
    flags("R10 set bit62", 0, 1);
    @(negedge clk);
    chk("R10 strobe one cycle", {63'd0, ctl_remap_strobe}, 64'd0);
    sb_acc(1, 6'h12, 64'h8000_0000_0000_0000, 0, "");
    flags("R10 other bit no strobe", 0, 0);
    sb_acc(0, 6'h0E, 0, 64'hC000_0000_0000_0003, "R5 ctl set");
    mm_acc(1, 8'h48, 64'h4000_0000_0000_0001, 0, "");
    flags("R10 mm clear bit62", 0, 1);
    mm_acc(0, 8'h20, 0, 64'h8000_0000_0000_0002, "R5 R1 ctl clear via mm");
    mm_acc(1, 8'h40, 64'h0000_0000_0000_0100, 0, "");
    sb_acc(0, 6'h0E, 0, 64'h8000_0000_0000_0102, "R5 mm set alias");

    // R6 base masking and lock
    sb_acc(1, 6'h0A, 64'hFFFF_FFFF_FFFF_FFFE, 0, "");
    flags("R6 sb base write", 0, 0);
    chk("R6 win_en off", {63'd0, win_en}, 64'd0);
    chk("R6 win_base masked", win_base, 64'h0003_FFFF_FFF0_0000);
    mm_acc(1, 8'h00, 64'h0000_0000_0010_0001, 0, "");
    flags("R6 mm base write rejected", 1, 0);
    chk("R6 win_en unchanged", {63'd0, win_en}, 64'd0);
    chk("R6 win_base unchanged", win_base, 64'h0003_FFFF_FFF0_0000);
    mm_acc(0, 8'h00, 0, 64'h0003_FFFF_FFF0_0000, "R6 R1 base via mm");
    sb_acc(1, 6'h0A, 64'h0000_0000_0020_0001, 0, "");
    @(negedge clk);
    chk("R6 win_en on", {63'd0, win_en}, 64'd1);
    chk("R6 win_base new", win_base, 64'h0000_0000_0020_0000);

    // R7 secondary base
    mm_acc(1, 8'h08, ONES, 0, "");
    sb_acc(0, 6'h0B, 0, 64'h0003_FFFF_0000_0000, "R7 sbase masked");

    // R8 read-only status and unmapped writes
    sb_acc(1, 6'h15, ONES, 0, "");
    flags("R8 status write", 1, 0);
    mm_acc(0, 8'h58, 0, 64'd0, "R8 status reads zero");
    sb_acc(1, 6'h20, ONES, 0, "");
    flags("R8 unmapped write", 1, 0);
    sb_acc(1, 6'h06, 64'h1, 0, "");
    flags("R8 R11 plain write accepted", 0, 0);

    // R11 plain registers
    sb_acc(1, 6'h07, 64'h0123_4567_89AB_CDEF, 0, "");
    mm_acc(1, 8'h50, 64'hFEDC_BA98_7654_3210, 0, "");
    sb_acc(1, 6'h0F, 64'h5555_AAAA_5555_AAAA, 0, "");
    sb_acc(0, 6'h06, 0, 64'h1, "R11 act0");
    sb_acc(0, 6'h07, 0, 64'h0123_4567_89AB_CDEF, "R11 act1");
    sb_acc(0, 6'h14, 0, 64'hFEDC_BA98_7654_3210, "R11 dma upper");
    mm_acc(0, 8'h28, 0, 64'h5555_AAAA_5555_AAAA, "R11 R1 mask via mm");

    // R3 all-ones reads
    sb_acc(0, 6'h01, 0, ONES, "R3 alias index reads ones");
    sb_acc(0, 6'h3F, 0, ONES, "R3 unmapped index reads ones");
    mm_acc(0, 8'h21, 0, ONES, "R1 misaligned read");
    mm_acc(1, 8'h21, 64'h0, 0, "");
    flags("R1 misaligned write", 1, 0);
    sb_acc(0, 6'h0E, 0, 64'h8000_0000_0000_0102, "R1 misaligned write ignored");

    // R2 priority
    sb_exp.push_back(64'hA500_A500_A500_A5FF); sb_tag.push_back("R2 sb served first");
    mm_exp.push_back(64'h8000_0000_0000_0102); mm_tag.push_back("R2 mm served after");
    sb_req = 1; sb_we = 0; sb_idx = 6'h00;
    mm_req = 1; mm_we = 0; mm_addr = 8'h20;
    #1;
    chk("R2 mm stalled", {63'd0, mm_ready}, 64'd0);
    @(posedge clk); #1;
    sb_req = 0;
    #1;
    chk("R2 mm ready when sb idle", {63'd0, mm_ready}, 64'd1);
    @(posedge clk); #1;
    mm_req = 0;

    repeat (4) @(negedge clk);
    chk("R3 all reads returned", 64'(sb_exp.size() + mm_exp.size()), 64'd0);
    finish_run();
  end
endmodule